// File: doc/BRIEF.md
# Dual-Field Multiply-Accumulate Unit

This block multiplies two 16-bit operands and folds the result into a 40-bit accumulator. A single partial-product array and a single adder array serve two kinds of arithmetic. In integer mode the operands are unsigned integers, which covers prime-field work. In polynomial mode the operands are bit vectors of GF(2) coefficients, and every carry in the datapath is suppressed, so each sum bit is the XOR of its inputs. Elliptic-curve code over either field type can build its long multiplications from this one primitive.

Partial products come from radix-4 digits by default. Each digit retires two multiplier bits and takes the values 0, 1, 2 or 3. The triple multiple is formed once, as x+2x in integer mode and as x XOR 2x in polynomial mode, so no digit is negative. A build-time parameter selects radix-2 instead, with one partial product per multiplier bit. The rows are summed by a regular array of ripple rows, not by a tree. A valid strobe accepts one operation per cycle. Each accepted operation either loads the fresh product or combines it with the accumulator. The result register and a one-cycle done pulse follow one clock later.

Top module: `dual_field_mac`

## Requirements
- R1: A synchronous active-high reset sets `acc_out` to 0 and `done` to 0.
- R2: With `mode_poly`=0, an accepted operation that loads forms the unsigned 32-bit product `op_a*op_b`, zero-extended to 40 bits.
- R3: With `mode_poly`=1, an accepted operation that loads forms the carry-less product of `op_a` and `op_b`, where bit k is the XOR over all i+j=k of `op_a[i]&op_b[j]`. Bit 31 of this product is always 0.
- R4: With `mode_poly`=0, `acc_en`=1 and `clear`=0, the new accumulator is the old one plus the product, modulo 2^40. Carries past bit 39 are dropped.
- R5: With `mode_poly`=1, `acc_en`=1 and `clear`=0, the new accumulator is the old one XOR the carry-less product.
- R6: `clear`=1 loads the product and discards the old accumulator, even when `acc_en`=1. With `acc_en`=0 the product is also loaded.
- R7: `done` is 1 in exactly the cycle after `in_valid` is sampled high. A new operation may be accepted on every cycle with no gaps.
- R8: While `in_valid` is 0, `acc_out` keeps its value and `done` is 0, whatever the other inputs do.
- R9: The radix-2 build (`RADIX4`=0) gives the same `acc_out` and `done` sequence as the radix-4 build.
- R10: The boundary operands give the expected products. A zero operand gives 0. `op_a`=1 passes `op_b` through. 0xFFFF×0xFFFF gives 0xFFFE0001 in integer mode and 0x55555555 in polynomial mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accepts an operation this cycle |
| mode_poly | input | 1 | 0: integer arithmetic, 1: GF(2) polynomial arithmetic |
| clear | input | 1 | Load the product, discarding the accumulator |
| acc_en | input | 1 | Combine the product with the accumulator |
| op_a | input | 16 | Multiplicand |
| op_b | input | 16 | Multiplier (recoded into digits) |
| acc_out | output | 40 | Registered accumulator |
| done | output | 1 | One-cycle pulse after an accepted operation |

## Verification
Assertions check several things on every cycle. The accumulator holds while no operation is accepted. A polynomial accumulate equals the old value XOR the array output. In polynomial mode the array never sets the top product bit. A unit or zero multiplicand gives the product these rules demand. Only the bench's scenarios can show the rest: full product values for arbitrary operands in both fields, wrap-around of long integer accumulations past 2^40, the precedence of clear over accumulate, back-to-back throughput, and agreement between the radix-2 and radix-4 builds.

// File: rtl/dfmac_pkg.sv
package dfmac_pkg;

  typedef enum logic {
    FLD_INT  = 1'b0,
    FLD_POLY = 1'b1
  } field_e;

  // Number of partial-product rows for a given operand width and radix.
  function automatic int pp_rows(input int op_w, input bit radix4);
    return radix4 ? (op_w + 1) / 2 : op_w;
  endfunction

endpackage

// File: rtl/dfmac_cpa.sv
// Ripple adder whose carry chain can be killed, turning it into a bitwise XOR.
module dfmac_cpa #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         kill,
  output logic [W-1:0] sum
);

  logic [W-1:0] c;

  assign c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    assign sum[i] = a[i] ^ b[i] ^ c[i];
    if (i < W - 1) begin : g_carry
      assign c[i+1] = ~kill & ((a[i] & b[i]) | (c[i] & (a[i] ^ b[i])));
    end
  end

endmodule

// File: rtl/dfmac_ppgen.sv
// Partial-product generator: radix-4 digits {0,1,2,3} or plain radix-2 bits.
module dfmac_ppgen #(
  parameter  int OP_W   = 16,
  parameter  bit RADIX4 = 1'b1,
  localparam int NPP    = dfmac_pkg::pp_rows(OP_W, RADIX4),
  localparam int PP_W   = OP_W + 2
) (
  input  logic [OP_W-1:0]          mcand,
  input  logic [OP_W-1:0]          mplier,
  input  logic                     poly,
  output logic [NPP-1:0][PP_W-1:0] pp
);

  logic [PP_W-1:0] x1;
  assign x1 = PP_W'(mcand);

  if (RADIX4) begin : g_r4
    localparam int MW = 2 * NPP;
    logic [MW-1:0]   mpad;
    logic [PP_W-1:0] x2;
    logic [PP_W-1:0] x3;

    assign mpad = MW'(mplier);
    assign x2   = x1 << 1;

    // Hard multiple: x + 2x (integer) or x ^ 2x (polynomial)
    dfmac_cpa #(.W(PP_W)) u_triple (
      .a   (x1),
      .b   (x2),
      .kill(poly),
      .sum (x3)
    );

    for (genvar j = 0; j < NPP; j++) begin : g_dig
      logic [1:0] d;
      assign d     = mpad[2*j +: 2];
      assign pp[j] = (d == 2'd0) ? '0 :
                     (d == 2'd1) ? x1 :
                     (d == 2'd2) ? x2 : x3;
    end
  end else begin : g_r2
    for (genvar j = 0; j < NPP; j++) begin : g_bit
      assign pp[j] = mplier[j] ? x1 : '0;
    end
  end

endmodule

// File: rtl/dfmac_pparray.sv
// Regular array of carry-killable ripple rows summing the shifted partial products.
module dfmac_pparray #(
  parameter  int OP_W   = 16,
  parameter  bit RADIX4 = 1'b1,
  localparam int NPP    = dfmac_pkg::pp_rows(OP_W, RADIX4),
  localparam int PP_W   = OP_W + 2,
  localparam int PROD_W = 2 * OP_W,
  localparam int STEP   = RADIX4 ? 2 : 1
) (
  input  logic [NPP-1:0][PP_W-1:0] pp,
  input  logic                     poly,
  output logic [PROD_W-1:0]        prod
);

  logic [NPP:0][PROD_W-1:0] row;

  assign row[0] = '0;

  for (genvar i = 0; i < NPP; i++) begin : g_row
    logic [PROD_W-1:0] sh;
    assign sh = PROD_W'(pp[i]) << (i * STEP);

    dfmac_cpa #(.W(PROD_W)) u_row (
      .a   (row[i]),
      .b   (sh),
      .kill(poly),
      .sum (row[i+1])
    );
  end

  assign prod = row[NPP];

endmodule

// File: rtl/dfmac_accum.sv
// Accumulator register: loads or combines the product, raises done one cycle later.
module dfmac_accum #(
  parameter int ACC_W  = 40,
  parameter int PROD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              poly,
  input  logic              keep,
  input  logic [PROD_W-1:0] prod,
  output logic [ACC_W-1:0]  acc_q,
  output logic              done_q
);

  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] nxt;

  assign base = keep ? acc_q : '0;

  dfmac_cpa #(.W(ACC_W)) u_acc_add (
    .a   (base),
    .b   (ACC_W'(prod)),
    .kill(poly),
    .sum (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= in_valid;
      if (in_valid) acc_q <= nxt;
    end
  end

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> $stable(acc_q));

  // R5
  poly_accum_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && poly && keep) && !$past(rst))
      |-> acc_q == ($past(acc_q) ^ ACC_W'($past(prod))));

endmodule

// File: rtl/dual_field_mac.sv
module dual_field_mac #(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 40,
  parameter bit RADIX4 = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             mode_poly,
  input  logic             clear,
  input  logic             acc_en,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic [ACC_W-1:0] acc_out,
  output logic             done
);
  import dfmac_pkg::*;

  localparam int NPP    = pp_rows(OP_W, RADIX4);
  localparam int PP_W   = OP_W + 2;
  localparam int PROD_W = 2 * OP_W;

  field_e fld;
  logic   poly;
  logic   keep;

  assign fld  = field_e'(mode_poly);
  assign poly = (fld == FLD_POLY);
  assign keep = acc_en & ~clear;

  logic [NPP-1:0][PP_W-1:0] pp;
  logic [PROD_W-1:0]        prod;

  dfmac_ppgen #(.OP_W(OP_W), .RADIX4(RADIX4)) u_ppgen (
    .mcand (op_a),
    .mplier(op_b),
    .poly  (poly),
    .pp    (pp)
  );

  dfmac_pparray #(.OP_W(OP_W), .RADIX4(RADIX4)) u_array (
    .pp  (pp),
    .poly(poly),
    .prod(prod)
  );

  dfmac_accum #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .poly    (poly),
    .keep    (keep),
    .prod    (prod),
    .acc_q   (acc_out),
    .done_q  (done)
  );

  // R3
  poly_top_bit_chk: assert property (@(posedge clk) disable iff (rst)
    poly |-> prod[PROD_W-1] == 1'b0);

  // R10
  unit_mcand_chk: assert property (@(posedge clk) disable iff (rst)
    (op_a == OP_W'(1)) |-> prod == PROD_W'(op_b));

  // R10
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (op_a == '0 || op_b == '0) |-> prod == '0);

endmodule

// File: tb/test_dual_field_mac.sv
module test_dual_field_mac;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, mode_poly, clear, acc_en;
  logic [15:0] op_a, op_b;
  logic [39:0] acc_r4, acc_r2;
  logic        done_r4, done_r2;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [39:0] exp_acc;
  logic        exp_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_field_mac i_dual_field_mac (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_poly(mode_poly),
    .clear(clear), .acc_en(acc_en), .op_a(op_a), .op_b(op_b),
    .acc_out(acc_r4), .done(done_r4)
  );

  dual_field_mac #(.RADIX4(1'b0)) i_dual_field_mac_r2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_poly(mode_poly),
    .clear(clear), .acc_en(acc_en), .op_a(op_a), .op_b(op_b),
    .acc_out(acc_r2), .done(done_r2)
  );

  function automatic logic [31:0] clmul(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] r = '0;
    for (int i = 0; i < 16; i++) if (b[i]) r = r ^ (32'(a) << i);
    return r;
  endfunction

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] want);
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL %s: got 0x%010h expected 0x%010h", tag, got, want);
    end
  endtask

  task automatic verify(input string tag);
    check(tag, acc_r4, exp_acc);
    check({tag, " done R7"}, 40'(done_r4), 40'(exp_done));
    check({tag, " radix-2 R9"}, acc_r2, exp_acc);
    check({tag, " radix-2 done R9"}, 40'(done_r2), 40'(exp_done));
  endtask

  // One clock: drive after a negedge, update the model at the posedge, check at the next negedge.
  task automatic op(input logic v, input logic m, input logic c, input logic e,
                    input logic [15:0] a, input logic [15:0] b, input string tag);
    logic [39:0] p;
    in_valid = v; mode_poly = m; clear = c; acc_en = e; op_a = a; op_b = b;
    @(posedge clk);
    p = m ? 40'(clmul(a, b)) : 40'(32'(a) * 32'(b));
    if (v) begin
      if (e && !c) exp_acc = m ? (exp_acc ^ p) : (exp_acc + p);
      else         exp_acc = p;
    end
    exp_done = v;
    @(negedge clk);
    verify(tag);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog: got running expected finished");
    summary();
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    rst = 1'b1; in_valid = 1'b0; mode_poly = 1'b0; clear = 1'b0; acc_en = 1'b0;
    op_a = '0; op_b = '0;
    exp_acc = '0; exp_done = 1'b0;
    repeat (3) @(negedge clk);
    verify("R1 reset");
    rst = 1'b0;

    // R2 integer load
    op(1, 0, 1, 0, 16'd3, 16'd5, "R2 int 3*5");
    op(1, 0, 1, 0, 16'h1234, 16'hABCD, "R2 int load");
    // R10 boundary operands
    op(1, 0, 1, 0, 16'hFFFF, 16'hFFFF, "R10 int all ones");
    op(1, 0, 1, 0, 16'h0000, 16'hBEEF, "R10 int zero");
    op(1, 1, 1, 0, 16'hFFFF, 16'hFFFF, "R10 poly all ones");
    op(1, 1, 1, 0, 16'h0001, 16'h8001, "R10 poly unit");
    // R3 polynomial load
    op(1, 1, 1, 0, 16'd3, 16'd3, "R3 poly (x+1)^2");
    op(1, 1, 0, 0, 16'h8000, 16'h8000, "R3 poly top terms");
    op(1, 1, 1, 0, 16'hA5C3, 16'h3C5A, "R3 poly mixed");
    // R6 clear overrides accumulate, acc_en=0 also loads
    op(1, 0, 1, 0, 16'd100, 16'd100, "R6 preload");
    op(1, 0, 1, 1, 16'd7, 16'd9, "R6 clear over acc_en");
    op(1, 0, 0, 0, 16'd11, 16'd13, "R6 acc_en low loads");
    // R4 integer accumulate
    op(1, 0, 0, 1, 16'h4321, 16'h0F0F, "R4 int acc");
    op(1, 0, 0, 1, 16'hFFFF, 16'h0002, "R4 int acc");
    // R8 idle cycles with changing inputs
    op(0, 1, 1, 1, 16'hDEAD, 16'hBEEF, "R8 hold");
    op(0, 0, 0, 1, 16'h1111, 16'h2222, "R8 hold");
    // R5 polynomial accumulate
    op(1, 1, 1, 0, 16'h00FF, 16'h0F0F, "R5 poly preload");
    op(1, 1, 0, 1, 16'h00FF, 16'h0F0F, "R5 poly self cancel");
    op(1, 1, 0, 1, 16'h1357, 16'h9BDF, "R5 poly acc");
    op(1, 1, 0, 1, 16'hFFFF, 16'h8421, "R5 poly acc");
    // R4 and R7: back-to-back accumulation past 2^40
    op(1, 0, 1, 0, 16'hFFFF, 16'hFFFF, "R4 wrap preload");
    for (int k = 0; k < 300; k++) op(1, 0, 0, 1, 16'hFFFF, 16'hFFFF, "R4 wrap back-to-back");
    // R7 mixed traffic from an LFSR
    for (int k = 0; k < 400; k++) begin
      logic [15:0] s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = lfsr;
      op(s[0] | s[1], s[2], s[3] & s[4], s[5] | s[6], lfsr ^ 16'h5A5A,
         {lfsr[7:0], lfsr[15:8]}, "R7 mixed stream");
    end
    // R1 reset mid-stream
    rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); exp_acc = '0; exp_done = 1'b0;
    @(negedge clk);
    verify("R1 reset again");
    rst = 1'b0;
    op(0, 0, 0, 0, 16'h0, 16'h0, "R8 idle after reset");
    summary();
  end

endmodule